// File: doc/BRIEF.md
# Endpoint Transaction-Done Interrupt Flags

This block keeps one sticky flag per device endpoint that records that a transaction on that endpoint has finished. The serial engine gives one-cycle outcome pulses for each endpoint: ACK sent or received, STALL sent, timeout, IN exception error, OUT exception error, and NAK. Any of the first five outcomes sets the endpoint's flag. A NAK sets it only when that endpoint's NAK interrupt enable is on.

Software reads the flags as a status word with one bit per endpoint. It clears them by writing ones. A single interrupt line is raised when any flag is set and that endpoint's interrupt enable is on.

Top module: `ep_done_irq`

## Requirements
- R1: The flag for endpoint i is at bit i of `status` (endpoint 0 at bit 0, 1 at bit 1, 2 at bit 2). A value of 1 means the transaction-done event occurred. Every bit at or above NUM_EP reads as 0.
- R2: A pulse on `ev_ack[i]` or `ev_stall[i]` in a cycle sets `status[i]` from the next clock edge on.
- R3: A pulse on `ev_timeout[i]`, `ev_in_err[i]` or `ev_out_err[i]` sets `status[i]` from the next clock edge on.
- R4: A pulse on `ev_nak[i]` sets `status[i]` only when `nak_irq_en[i]` is 1. When `nak_irq_en[i]` is 0, the NAK has no effect on any flag.
- R5: A cycle with `clr_we` = 1 clears each flag whose `clr_data` bit is 1. Flags whose `clr_data` bit is 0 are left unchanged.
- R6: Flags are sticky. A set flag stays set until it is cleared by a write.
- R7: If an outcome pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` equals the OR over all endpoints of the flag ANDed with `irq_en`. It follows the flags and enables with no added cycle.
- R9: An active-low `rst_n` clears all flags, so `status` and `irq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ack | input | NUM_EP | ACK sent/received pulse per endpoint |
| ev_stall | input | NUM_EP | STALL sent pulse per endpoint |
| ev_timeout | input | NUM_EP | Timeout pulse per endpoint |
| ev_in_err | input | NUM_EP | IN exception error pulse per endpoint |
| ev_out_err | input | NUM_EP | OUT exception error pulse per endpoint |
| ev_nak | input | NUM_EP | NAK given pulse per endpoint |
| nak_irq_en | input | NUM_EP | Per-endpoint NAK interrupt enable |
| irq_en | input | NUM_EP | Per-endpoint interrupt enable |
| clr_we | input | 1 | Clear write strobe |
| clr_data | input | NUM_EP | Write-one-to-clear mask |
| status | output | STAT_W | Flag status word |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- each enabled outcome leaves its flag set on the next edge, whatever clear arrives with it;
- flags never drop without a clear write;
- a clear with no concurrent outcome removes exactly the masked bits;
- reserved bits stay zero;
- `irq` tracks the enabled flags.

Some behaviours only the bench scenarios can show. A NAK whose enable is off must leave the flags alone, which the bench checks for every endpoint. The bench also covers the full grid of flag patterns against clear masks and against interrupt enables, and the cleared state after a reset taken in the middle of a run.

// File: rtl/ep_done_irq.sv
module ep_done_irq #(
  parameter int NUM_EP = 3,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_ack,
  input  logic [NUM_EP-1:0] ev_stall,
  input  logic [NUM_EP-1:0] ev_timeout,
  input  logic [NUM_EP-1:0] ev_in_err,
  input  logic [NUM_EP-1:0] ev_out_err,
  input  logic [NUM_EP-1:0] ev_nak,
  input  logic [NUM_EP-1:0] nak_irq_en,
  input  logic [NUM_EP-1:0] irq_en,
  input  logic              clr_we,
  input  logic [NUM_EP-1:0] clr_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam int PAD = STAT_W - NUM_EP;

  logic [NUM_EP-1:0] flag_q;
  logic [NUM_EP-1:0] hit;
  logic [NUM_EP-1:0] clr;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign hit[i] = ev_ack[i] | ev_stall[i] | ev_timeout[i] |
                    ev_in_err[i] | ev_out_err[i] |
                    (ev_nak[i] & nak_irq_en[i]);
  end

  assign clr = clr_we ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | hit;

  if (PAD > 0) begin : g_pad
    assign status = {{PAD{1'b0}}, flag_q};
  end else begin : g_nopad
    assign status = flag_q;
  end

  assign irq = |(flag_q & irq_en);
endmodule

module ep_done_irq_chk #(
  parameter int NUM_EP = 3,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ev_ack,
  input logic [NUM_EP-1:0] ev_stall,
  input logic [NUM_EP-1:0] ev_timeout,
  input logic [NUM_EP-1:0] ev_in_err,
  input logic [NUM_EP-1:0] ev_out_err,
  input logic [NUM_EP-1:0] ev_nak,
  input logic [NUM_EP-1:0] nak_irq_en,
  input logic [NUM_EP-1:0] irq_en,
  input logic              clr_we,
  input logic [NUM_EP-1:0] clr_data,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  logic [NUM_EP-1:0] hs_ev, err_ev, nak_ev, any_ev;
  assign hs_ev  = ev_ack | ev_stall;
  assign err_ev = ev_timeout | ev_in_err | ev_out_err;
  assign nak_ev = ev_nak & nak_irq_en;
  assign any_ev = hs_ev | err_ev | nak_ev;

  // R2
  handshake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hs_ev) |=> ((status[NUM_EP-1:0] & $past(hs_ev)) == $past(hs_ev)));

  // R3
  error_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_ev) |=> ((status[NUM_EP-1:0] & $past(err_ev)) == $past(err_ev)));

  // R4
  nak_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|nak_ev) |=> ((status[NUM_EP-1:0] & $past(nak_ev)) == $past(nak_ev)));

  // R5
  clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !(|any_ev)) |=>
      (status[NUM_EP-1:0] == ($past(status[NUM_EP-1:0]) & ~$past(clr_data))));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status[NUM_EP-1:0] & $past(status[NUM_EP-1:0])) ==
                 $past(status[NUM_EP-1:0])));

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (|(any_ev & clr_data))) |=>
      ((status[NUM_EP-1:0] & $past(any_ev)) == $past(any_ev)));

  // R8
  irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(status[NUM_EP-1:0] & irq_en)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (status == '0 && !irq));

  if (STAT_W > NUM_EP) begin : g_rsv
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[STAT_W-1:NUM_EP] == '0);
  end
endmodule

bind ep_done_irq ep_done_irq_chk #(.NUM_EP(NUM_EP), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/test_ep_done_irq.sv
module test_ep_done_irq;
  localparam int N = 3;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] ev_ack, ev_stall, ev_timeout, ev_in_err, ev_out_err, ev_nak;
  logic [N-1:0] nak_irq_en, irq_en, clr_data;
  logic clr_we;
  logic [W-1:0] status;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ep_done_irq #(.NUM_EP(N), .STAT_W(W)) i_ep_done_irq (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic zero_in();
    ev_ack = '0; ev_stall = '0; ev_timeout = '0; ev_in_err = '0;
    ev_out_err = '0; ev_nak = '0; clr_we = 0; clr_data = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); zero_in(); clr_we = 1; clr_data = '1;
    @(negedge clk); zero_in();
  endtask

  task automatic set_ack(logic [N-1:0] m);
    @(negedge clk); zero_in(); ev_ack = m;
    @(negedge clk); zero_in();
  endtask

  initial begin
    zero_in(); nak_irq_en = '0; irq_en = '0;
    repeat (3) @(negedge clk);
    // R9: state under reset
    chk("R9", status, '0);
    chk("R9", {15'd0, irq}, '0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4: every endpoint, every outcome, NAK enable on/off
    for (int ep = 0; ep < N; ep++)
      for (int kind = 0; kind < 6; kind++)
        for (int nen = 0; nen < 2; nen++) begin
          logic [N-1:0] one;
          logic [W-1:0] exp;
          string rq;
          one = N'(1 << ep);
          clear_all();
          nak_irq_en = nen ? one : ~one;
          @(negedge clk);
          case (kind)
            0: ev_ack = one;
            1: ev_stall = one;
            2: ev_timeout = one;
            3: ev_in_err = one;
            4: ev_out_err = one;
            default: ev_nak = one;
          endcase
          @(negedge clk); zero_in();
          exp = (kind == 5 && nen == 0) ? '0 : W'(one);
          rq = (kind < 2) ? "R2/R1" : (kind < 5) ? "R3/R1" : "R4";
          chk(rq, status, exp);
        end
    nak_irq_en = '0;

    // R5 R6: every flag pattern against every clear mask
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++) begin
        clear_all();
        set_ack(N'(p));
        repeat (2) @(negedge clk);
        chk("R6", status, W'(p));
        @(negedge clk); clr_we = 1; clr_data = N'(c);
        @(negedge clk); zero_in();
        chk("R5", status, W'(p & ~c));
      end

    // R7: outcome and clear on the same cycle
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++) begin
        set_ack('1);
        @(negedge clk); ev_timeout = N'(p); clr_we = 1; clr_data = N'(c);
        @(negedge clk); zero_in();
        chk("R7", status, W'((7 & ~c) | p));
      end

    // R8: flags against interrupt enables
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < 8; e++) begin
        clear_all();
        set_ack(N'(f));
        irq_en = N'(e);
        #1;
        chk("R8", {15'd0, irq}, {15'd0, |(f & e)});
      end

    // R9: reset in mid-run
    irq_en = '1;
    set_ack('1);
    @(negedge clk); rst_n = 0;
    #1;
    chk("R9", status, '0);
    chk("R9", {15'd0, irq}, '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R9", status, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule